// File: doc/BRIEF.md
# Character LCD Host Write Engine

This block sits between a host and a character LCD module that has a 16-column by 2-row text field. It runs once the power-up initialization is finished. The host puts an ASCII code on its data bus and pulls its active-low write strobe low. The engine then writes that code into the display's data register. Next it reads the display's busy flag over the same bidirectional bus, as many times as needed, and only then gives the host an active-low acknowledge pulse. If the host keeps the strobe low, the engine repeats the write once per acknowledge.

The display's internal RAM addresses for row 0 and row 1 do not follow each other. To handle this, the engine tracks the cursor itself. After the last column of row 0 it sends the set-address command 0xC0. After the last column of row 1 it sends 0x80, which returns the cursor to row 0, column 0. It polls the busy flag after each of these commands as well, before it acknowledges the host.

The bus is shared with an initialization sequencer, so a grant input decides when the engine may start a transaction. A settable timeout stops the busy polling if the flag never clears. When that happens the engine sets a sticky error flag and still completes the handshake.

Top module: `lcd_char_writer`

## Requirements
- R1: After reset the acknowledge output is high, E is low and the timeout error flag is low. The cursor is at row 0, column 0, so the 16th character after reset is followed by the command 0xC0.
- R2: When `bus_grant` is high and `host_we_n` is low while the engine is idle, the engine captures `host_data`. It writes the captured byte to the display with RS=1 and RW=0, and the display latches it on the falling edge of E.
- R3: Changes on `host_data` after the capture, and before the acknowledge, do not change the byte that is written.
- R4: After each byte or command written, the engine runs read cycles with RS=0 and RW=1 and releases DB. It samples DB bit 7 while E is high (1 = busy) and repeats the read until the sample is 0.
- R5: `host_ack_n` is low for exactly one clock per write. That clock comes only after the last busy poll of that write (including any address command) has found the display ready. E is low during that clock.
- R6: When a character has been written to column 15 of row 0, the engine writes the command byte 0xC0 (RS=0, RW=0) and polls busy before it acknowledges.
- R7: When a character has been written to column 15 of row 1, the engine writes the command byte 0x80 (RS=0, RW=0) and polls busy before it acknowledges. The next character goes to row 0, column 0.
- R8: While `host_we_n` stays low, the engine writes the current `host_data` once per acknowledge, with no other bus traffic between writes.
- R9: While `bus_grant` is low and the engine is idle, no transaction starts. E stays low and no acknowledge is given.
- R10: If a poll sequence has run for `TIMEOUT_CYC` cycles and the last sample still shows busy, the engine stops polling and sets `timeout_err`. The flag stays high until reset, and the engine still completes the write and acknowledges.
- R11: Each E pulse is high for exactly `PULSE_CYC` clocks. RS and RW are stable while E is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_grant | input | 1 | High when initialization is done and the display bus belongs to this engine |
| host_data | input | 8 | ASCII code to display |
| host_we_n | input | 1 | Active-low write request from the host |
| host_ack_n | output | 1 | Active-low one-clock acknowledge: the byte is on the display and the engine is ready |
| lcd_rs | output | 1 | Register select: 1 = data register, 0 = command/status |
| lcd_rw | output | 1 | 1 = read from the display, 0 = write |
| lcd_e | output | 1 | Enable strobe; the display latches on its falling edge |
| lcd_db | inout | 8 | Display data bus, released during reads |
| timeout_err | output | 1 | Sticky flag: a busy poll timed out |

## Verification
The bound checker watches the bus rules on every cycle. These are: reads always use the command/status register, DB is released during reads, control lines are stable while E is high, the acknowledge is a single cycle with E low, the error flag is sticky, and no transaction starts without the grant. Other behaviour can only be shown by the bench's scenarios against its display model. This includes the byte actually latched (including data changing in the middle of a write), repeated polling against a display that stays busy, the 0xC0 and 0x80 address commands at the two row ends, repeated writes while the strobe is held, and the timeout path with a display that never becomes ready.

// File: rtl/lcd_wr_pkg.sv
package lcd_wr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WR_DATA,
        ST_POLL_DATA,
        ST_WR_CMD,
        ST_POLL_CMD,
        ST_ACK
    } wr_state_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SETUP,
        PH_HIGH,
        PH_HOLD
    } phase_e;

    typedef struct packed {
        logic       rs;
        logic       rw;
        logic [7:0] val;
    } bus_req_t;

    // set-address command that homes the cursor on a row
    function automatic logic [7:0] row_home_cmd(input logic row);
        return {1'b1, row, 6'd0};
    endfunction

    function automatic bus_req_t mk_data(input logic [7:0] b);
        return '{rs: 1'b1, rw: 1'b0, val: b};
    endfunction

    function automatic bus_req_t mk_cmd(input logic [7:0] b);
        return '{rs: 1'b0, rw: 1'b0, val: b};
    endfunction

    function automatic bus_req_t mk_status_read();
        return '{rs: 1'b0, rw: 1'b1, val: 8'h00};
    endfunction

endpackage

// File: rtl/lcd_bus_phy.sv
module lcd_bus_phy
    import lcd_wr_pkg::*;
#(
    parameter int SETUP_CYC = 2,
    parameter int PULSE_CYC = 4,
    parameter int HOLD_CYC  = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  bus_req_t   req,
    input  logic       busy_bit,
    output logic       done,
    output logic       busy_flag,
    output logic       idle,
    output logic       rs,
    output logic       rw,
    output logic       e,
    output logic       db_oe,
    output logic [7:0] db_out
);
    localparam int MAX_AB = (SETUP_CYC > PULSE_CYC) ? SETUP_CYC : PULSE_CYC;
    localparam int MAXC   = (MAX_AB > HOLD_CYC) ? MAX_AB : HOLD_CYC;
    localparam int CW     = (MAXC > 1) ? $clog2(MAXC) : 1;
    localparam logic [CW-1:0] SETUP_LD = CW'(SETUP_CYC - 1);
    localparam logic [CW-1:0] PULSE_LD = CW'(PULSE_CYC - 1);
    localparam logic [CW-1:0] HOLD_LD  = CW'(HOLD_CYC - 1);

    phase_e        ph;
    logic [CW-1:0] cnt;
    bus_req_t      cur;
    logic          last;

    assign last = (cnt == '0);
    assign done = (ph == PH_HOLD) && last;
    assign idle = (ph == PH_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            ph        <= PH_IDLE;
            cnt       <= '0;
            cur       <= '0;
            busy_flag <= 1'b0;
        end else begin
            unique case (ph)
                PH_IDLE: begin
                    if (start) begin
                        cur <= req;
                        ph  <= PH_SETUP;
                        cnt <= SETUP_LD;
                    end
                end
                PH_SETUP: begin
                    if (last) begin
                        ph  <= PH_HIGH;
                        cnt <= PULSE_LD;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_HIGH: begin
                    if (last) begin
                        if (cur.rw) busy_flag <= busy_bit;
                        ph  <= PH_HOLD;
                        cnt <= HOLD_LD;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_HOLD: begin
                    if (last) begin
                        if (start) begin
                            cur <= req;
                            ph  <= PH_SETUP;
                            cnt <= SETUP_LD;
                        end else begin
                            ph <= PH_IDLE;
                        end
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: ph <= PH_IDLE;
            endcase
        end
    end

    assign e      = (ph == PH_HIGH);
    assign rs     = idle ? 1'b0 : cur.rs;
    assign rw     = idle ? 1'b0 : cur.rw;
    assign db_oe  = !idle && !cur.rw;
    assign db_out = cur.val;

endmodule

// File: rtl/lcd_cursor_trk.sv
module lcd_cursor_trk
    import lcd_wr_pkg::*;
#(
    parameter int COLS = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       advance,
    input  logic       take,
    output logic       pend,
    output logic [7:0] pend_cmd
);
    localparam int CCW = (COLS > 1) ? $clog2(COLS) : 1;
    localparam logic [CCW-1:0] LAST_COL = CCW'(COLS - 1);

    logic [CCW-1:0] col;
    logic           row;

    always_ff @(posedge clk) begin
        if (rst) begin
            col      <= '0;
            row      <= 1'b0;
            pend     <= 1'b0;
            pend_cmd <= 8'h00;
        end else if (advance) begin
            if (col == LAST_COL) begin
                col      <= '0;
                row      <= ~row;
                pend     <= 1'b1;
                pend_cmd <= row_home_cmd(~row);
            end else begin
                col <= col + 1'b1;
            end
        end else if (take) begin
            pend <= 1'b0;
        end
    end

endmodule

// File: rtl/lcd_poll_timer.sv
module lcd_poll_timer #(
    parameter int TIMEOUT_CYC = 4096
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic run,
    output logic expired
);
    localparam int TW = $clog2(TIMEOUT_CYC + 1);
    localparam logic [TW-1:0] LIMIT = TW'(TIMEOUT_CYC);

    logic [TW-1:0] cnt;

    assign expired = (cnt >= LIMIT);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt <= '0;
        end else if (run && !expired) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/lcd_char_writer.sv
module lcd_char_writer
    import lcd_wr_pkg::*;
#(
    parameter int COLS        = 16,
    parameter int SETUP_CYC   = 2,
    parameter int PULSE_CYC   = 4,
    parameter int HOLD_CYC    = 2,
    parameter int TIMEOUT_CYC = 4096
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bus_grant,
    input  logic [7:0] host_data,
    input  logic       host_we_n,
    output logic       host_ack_n,
    output logic       lcd_rs,
    output logic       lcd_rw,
    output logic       lcd_e,
    inout  wire  [7:0] lcd_db,
    output logic       timeout_err
);
    wr_state_e  state, nxt_state;
    logic       phy_start, phy_done, phy_busy, phy_idle;
    bus_req_t   phy_req;
    logic       db_oe;
    logic [7:0] db_out;
    logic       cur_adv, cur_take, cur_pend;
    logic [7:0] cur_cmd;
    logic       tmr_clear, tmr_run, tmr_exp;
    logic       set_err;
    logic       active;

    lcd_bus_phy #(
        .SETUP_CYC(SETUP_CYC),
        .PULSE_CYC(PULSE_CYC),
        .HOLD_CYC (HOLD_CYC)
    ) u_phy (
        .clk      (clk),
        .rst      (rst),
        .start    (phy_start),
        .req      (phy_req),
        .busy_bit (lcd_db[7]),
        .done     (phy_done),
        .busy_flag(phy_busy),
        .idle     (phy_idle),
        .rs       (lcd_rs),
        .rw       (lcd_rw),
        .e        (lcd_e),
        .db_oe    (db_oe),
        .db_out   (db_out)
    );

    lcd_cursor_trk #(.COLS(COLS)) u_cursor (
        .clk     (clk),
        .rst     (rst),
        .advance (cur_adv),
        .take    (cur_take),
        .pend    (cur_pend),
        .pend_cmd(cur_cmd)
    );

    lcd_poll_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .clear  (tmr_clear),
        .run    (tmr_run),
        .expired(tmr_exp)
    );

    assign lcd_db  = db_oe ? db_out : 8'hzz;
    assign tmr_run = (state == ST_POLL_DATA) || (state == ST_POLL_CMD);
    assign active  = (state != ST_IDLE) || !phy_idle;

    always_comb begin
        nxt_state = state;
        phy_start = 1'b0;
        phy_req   = mk_status_read();
        cur_adv   = 1'b0;
        cur_take  = 1'b0;
        tmr_clear = 1'b0;
        set_err   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (bus_grant && !host_we_n) begin
                    phy_start = 1'b1;
                    phy_req   = mk_data(host_data);
                    nxt_state = ST_WR_DATA;
                end
            end
            ST_WR_DATA: begin
                if (phy_done) begin
                    phy_start = 1'b1;
                    tmr_clear = 1'b1;
                    cur_adv   = 1'b1;
                    nxt_state = ST_POLL_DATA;
                end
            end
            ST_POLL_DATA: begin
                if (phy_done) begin
                    if (phy_busy && !tmr_exp) begin
                        phy_start = 1'b1;
                    end else begin
                        set_err = phy_busy;
                        if (cur_pend) begin
                            phy_start = 1'b1;
                            phy_req   = mk_cmd(cur_cmd);
                            cur_take  = 1'b1;
                            nxt_state = ST_WR_CMD;
                        end else begin
                            nxt_state = ST_ACK;
                        end
                    end
                end
            end
            ST_WR_CMD: begin
                if (phy_done) begin
                    phy_start = 1'b1;
                    tmr_clear = 1'b1;
                    nxt_state = ST_POLL_CMD;
                end
            end
            ST_POLL_CMD: begin
                if (phy_done) begin
                    if (phy_busy && !tmr_exp) begin
                        phy_start = 1'b1;
                    end else begin
                        set_err   = phy_busy;
                        nxt_state = ST_ACK;
                    end
                end
            end
            ST_ACK:  nxt_state = ST_IDLE;
            default: nxt_state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            timeout_err <= 1'b0;
        end else begin
            state <= nxt_state;
            if (set_err) timeout_err <= 1'b1;
        end
    end

    assign host_ack_n = (state != ST_ACK);

endmodule

// File: rtl/lcd_char_writer_chk.sv
module lcd_char_writer_chk (
    input logic clk,
    input logic rst,
    input logic bus_grant,
    input logic host_ack_n,
    input logic lcd_rs,
    input logic lcd_rw,
    input logic lcd_e,
    input logic timeout_err,
    input logic db_oe,
    input logic active
);
    a_r5_ack_single: assert property (@(posedge clk) disable iff (rst)
        !host_ack_n |=> host_ack_n);

    a_r5_ack_e_low: assert property (@(posedge clk) disable iff (rst)
        !host_ack_n |-> !lcd_e);

    a_r4_read_status_reg: assert property (@(posedge clk) disable iff (rst)
        lcd_rw |-> !lcd_rs);

    a_r4_bus_released: assert property (@(posedge clk) disable iff (rst)
        lcd_rw |-> !db_oe);

    a_r11_ctrl_stable: assert property (@(posedge clk) disable iff (rst)
        (lcd_e && $past(lcd_e)) |-> ($stable(lcd_rs) && $stable(lcd_rw)));

    a_r10_err_sticky: assert property (@(posedge clk) disable iff (rst)
        timeout_err |=> timeout_err);

    a_r9_no_start: assert property (@(posedge clk) disable iff (rst)
        (!active && !bus_grant) |=> !active);

endmodule

bind lcd_char_writer lcd_char_writer_chk i_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_grant  (bus_grant),
    .host_ack_n (host_ack_n),
    .lcd_rs     (lcd_rs),
    .lcd_rw     (lcd_rw),
    .lcd_e      (lcd_e),
    .timeout_err(timeout_err),
    .db_oe      (db_oe),
    .active     (active)
);

// File: tb/test_lcd_char_writer.sv
module test_lcd_char_writer;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int P_SETUP   = 2;
    localparam int P_PULSE   = 4;
    localparam int P_HOLD    = 2;
    localparam int P_TMO     = 200;
    localparam int BUSY_HOLD = 20;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_grant = 1'b0;
    logic [7:0] host_data = 8'h00;
    logic       host_we_n = 1'b1;
    wire        host_ack_n, lcd_rs, lcd_rw, lcd_e, timeout_err;
    wire  [7:0] lcd_db;

    always #2.5 clk = ~clk;

    lcd_char_writer #(
        .COLS(16), .SETUP_CYC(P_SETUP), .PULSE_CYC(P_PULSE),
        .HOLD_CYC(P_HOLD), .TIMEOUT_CYC(P_TMO)
    ) i_lcd_char_writer (
        .clk(clk), .rst(rst), .bus_grant(bus_grant), .host_data(host_data),
        .host_we_n(host_we_n), .host_ack_n(host_ack_n), .lcd_rs(lcd_rs),
        .lcd_rw(lcd_rw), .lcd_e(lcd_e), .lcd_db(lcd_db), .timeout_err(timeout_err)
    );

    // display model state
    int         busy_cnt = 0;
    bit         stuck = 0;
    bit         e_prev = 0;
    int         e_len = 0;
    int         reads_since = 0;
    int         last_reads = 0;
    logic [8:0] exp_q[$];
    int         row_m = 0, col_m = 0;
    int         ack_cnt = 0;
    bit         outstanding = 0;
    int         hold_left = 0;
    logic [7:0] hold_char = 8'h00;
    bit         ack_prev = 0;
    bit         grant_block = 0;
    int         seen_c0 = 0, seen_80 = 0;
    string      tag = "R1";
    int         checks = 0, errors = 0, cyc = 0;

    assign lcd_db = (lcd_e && lcd_rw) ? {((busy_cnt != 0) || stuck), 7'b0} : 8'hzz;

    task automatic check(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    function automatic void push_expect(input logic [7:0] c);
        exp_q.push_back({1'b1, c});
        col_m++;
        if (col_m == 16) begin
            col_m = 0;
            exp_q.push_back({1'b0, (row_m == 0) ? 8'hC0 : 8'h80});
            row_m = 1 - row_m;
        end
    endfunction

    // reference model of the display and per-clock comparison
    always @(negedge clk) begin
        logic [8:0] exp_v;
        cyc++;
        if (cyc > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
        if (rst) begin
            e_prev = 0; e_len = 0; ack_prev = 0;
        end else begin
            if (busy_cnt > 0) busy_cnt--;
            if (lcd_e) e_len++;
            if (e_prev && !lcd_e) begin
                check(e_len == P_PULSE, "R11 E high width", e_len, P_PULSE);
                e_len = 0;
                if (!lcd_rw) begin
                    if (exp_q.size() == 0) begin
                        check(0, {tag, " unexpected bus write"}, {lcd_rs, lcd_db}, 0);
                    end else begin
                        exp_v = exp_q.pop_front();
                        check({lcd_rs, lcd_db} == exp_v, {tag, " latched rs/byte"},
                              {lcd_rs, lcd_db}, exp_v);
                    end
                    if (!lcd_rs && lcd_db == 8'hC0) seen_c0++;
                    if (!lcd_rs && lcd_db == 8'h80) seen_80++;
                    busy_cnt = BUSY_HOLD;
                    reads_since = 0;
                end else begin
                    reads_since++;
                end
            end
            if (lcd_e && lcd_rw)
                check(!lcd_rs, "R4 read selects status register", lcd_rs, 0);
            if (grant_block)
                check(!lcd_e && host_ack_n, "R9 idle without grant", {lcd_e, host_ack_n}, 1);
            if (!host_ack_n) begin
                check(!ack_prev, "R5 ack one cycle", ack_prev, 0);
                check(outstanding, "R5 ack without request", outstanding, 1);
                check(exp_q.size() == 0, {tag, " all bytes latched before ack"}, exp_q.size(), 0);
                check(!lcd_e, "R5 E low during ack", lcd_e, 0);
                if (!stuck) check(busy_cnt == 0, "R4 ack while display busy", busy_cnt, 0);
                check(reads_since >= 1, "R4 busy read before ack", reads_since, 1);
                last_reads = reads_since;
                ack_cnt++;
                if (hold_left > 0) begin
                    push_expect(hold_char);
                    hold_left--;
                end else begin
                    outstanding = 0;
                end
            end
            ack_prev = !host_ack_n;
            e_prev = lcd_e;
        end
    end

    task automatic wr(input logic [7:0] c, input bit swap);
        int start;
        start = ack_cnt;
        push_expect(c);
        outstanding = 1;
        host_data = c;
        host_we_n = 1'b0;
        if (swap) begin
            repeat (3) @(negedge clk);
            host_data = c ^ 8'h55;
        end
        wait (ack_cnt != start);
        host_we_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic hold_we(input logic [7:0] c, input int n);
        int start;
        start = ack_cnt;
        push_expect(c);
        hold_char = c;
        hold_left = n - 1;
        outstanding = 1;
        host_data = c;
        host_we_n = 1'b0;
        wait (ack_cnt == start + n);
        host_we_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        bus_grant = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(host_ack_n == 1'b1, "R1 ack high after reset", host_ack_n, 1);
        check(lcd_e == 1'b0, "R1 E low after reset", lcd_e, 0);
        check(timeout_err == 1'b0, "R1 no error after reset", timeout_err, 0);

        // R2 and R4: single write with repeated busy polling
        tag = "R2";
        wr(8'h41, 0);
        check(last_reads >= 2, "R4 repeated busy polls", last_reads, 2);
        check(timeout_err == 1'b0, "R10 no timeout on normal busy", timeout_err, 0);

        // R3: data changes mid-write are ignored
        tag = "R3";
        wr(8'h42, 1);

        // R6: end of row 0 gives 0xC0
        tag = "R6";
        for (int i = 0; i < 14; i++) wr(8'h61 + 8'(i), 0);
        check(seen_c0 == 1, "R6 row 1 address command", seen_c0, 1);

        // R9: no start while grant is low
        tag = "R9";
        bus_grant = 1'b0;
        grant_block = 1;
        host_data = 8'h67;
        host_we_n = 1'b0;
        repeat (40) @(negedge clk);
        grant_block = 0;
        host_we_n = 1'b1;
        bus_grant = 1'b1;
        wr(8'h67, 0);

        // R8: strobe held low
        tag = "R8";
        hold_we(8'h68, 5);
        repeat (40) @(negedge clk);
        check(exp_q.size() == 0, "R8 no extra write after release", exp_q.size(), 0);

        // R7: end of row 1 gives 0x80
        tag = "R7";
        for (int i = 0; i < 10; i++) wr(8'h30 + 8'(i), 0);
        check(seen_80 == 1, "R7 row 0 address command", seen_80, 1);
        wr(8'h7A, 0);

        // R10: display never ready
        tag = "R10";
        stuck = 1;
        wr(8'h54, 0);
        check(timeout_err == 1'b1, "R10 timeout flag set", timeout_err, 1);
        stuck = 0;
        repeat (30) @(negedge clk);
        wr(8'h55, 0);
        check(timeout_err == 1'b1, "R10 timeout flag sticky", timeout_err, 1);

        // R1: reset clears error and homes the cursor
        rst = 1'b1;
        exp_q.delete();
        busy_cnt = 0; row_m = 0; col_m = 0; outstanding = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(timeout_err == 1'b0, "R1 reset clears error", timeout_err, 1'b0);
        check(host_ack_n == 1'b1, "R1 ack high after second reset", host_ack_n, 1);
        tag = "R1";
        for (int i = 0; i < 16; i++) wr(8'h50 + 8'(i), 0);
        check(seen_c0 == 2, "R1 cursor at origin after reset", seen_c0, 2);

        repeat (20) @(negedge clk);
        check(exp_q.size() == 0, "R2 no pending expected bytes", exp_q.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule